// File: doc/BRIEF.md
# Interrupt Moderation Throttle

This block sits between an event source and a host interrupt line and limits how often the host is interrupted. Each interrupt it raises starts a programmable quiet gap. Events that arrive inside the gap are not lost. They are merged into one pending flag, and that flag raises a single interrupt once the gap has run out. As a result a minimum spacing between interrupts holds however heavy the event traffic is.

Time is counted in units of 250 ns. A prescaler with a parameterised divide ratio derives a one-cycle tick from the system clock. Software sees one 32-bit register. The low half holds the gap length in ticks and the high half holds the live countdown. Either half can be written on its own. The gap length resets to 4000 ticks (1 ms). A length of 512 therefore gives at least 128 µs between interrupts. A length of zero turns throttling off.

Top module: `irq_throttle`

## Requirements
- R1: After reset the register reads 32'h0000_0FA0: the interval (bits 15:0) is 4000, the countdown (bits 31:16) is 0, and irq_o is low.
- R2: reg_we_i[0] writes bits 15:0 of reg_wdata_i into the interval. reg_we_i[1] writes bits 31:16 into the countdown. The field that is not enabled is unchanged. reg_rdata_o shows the new contents from the clock edge that performs the write.
- R3: While the countdown is nonzero it drops by exactly one every TICK_DIV clock cycles. Once at zero it stays at zero.
- R4: When irq_o is low and the countdown is zero, an event pulse raises irq_o on the second rising edge after the pulse is sampled.
- R5: On the edge that raises irq_o, the countdown loads the interval value that was held before that edge.
- R6: irq_o stays high until ack_i is sampled high. That edge lowers irq_o and also clears every event seen before it.
- R7: Any number of events that arrive while irq_o is low and the countdown is running produce exactly one interrupt.
- R8: With a nonzero interval I, events held on and every interrupt acknowledged at once, the spacing between successive rising edges of irq_o is at least (I-1)*TICK_DIV+2 and at most I*TICK_DIV+1 clock cycles.
- R9: With an interval of zero, held events re-raise irq_o two cycles after each rise, which is the acknowledge turnaround alone.
- R10: A write to the countdown replaces the running count at once. Writing zero releases a pending interrupt on the next edge.
- R11: Without an event, irq_o never rises. An acknowledge while irq_o is low neither raises irq_o nor discards a pending event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | Event indication, one or more cycles high |
| ack_i | input | 1 | Host acknowledge of the interrupt |
| reg_we_i | input | 2 | Field write enables: bit 0 interval, bit 1 countdown |
| reg_wdata_i | input | 2*CNT_W | Write data: countdown in upper half, interval in lower half |
| reg_rdata_o | output | 2*CNT_W | Register contents: countdown upper, interval lower |
| irq_o | output | 1 | Interrupt to host, level, held until acknowledged |

## Verification
A wrong countdown shows up in the countdown half of the register on the very next cycle. The readback is taken from the state after each edge, so a skipped or doubled decrement is visible at once as a step that does not match the TICK_DIV cadence. A prescaler that is off by one does not change any single value. It only shifts the spacing of interrupts, so the bench measures the gaps across a sweep of interval values and compares them with an arithmetic window. A lost or sticky pending flag shows within one gap length, as a missing interrupt or an extra one after the gap expires.

// File: rtl/irq_thr_pkg.sv
package irq_thr_pkg;

  // Field write-enable lanes of the moderation register
  localparam int WE_IVAL = 0;
  localparam int WE_CNT  = 1;

  // Next-state selection for the countdown
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_DEC  = 2'd1,
    CNT_LOAD = 2'd2,
    CNT_SET  = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/irq_thr_tick.sv
module irq_thr_tick #(
  parameter int DIV = 25
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);

  generate
    if (DIV <= 1) begin : g_every
      always_ff @(posedge clk) begin
        tick_o <= !rst;
      end
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] ph_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          ph_q   <= '0;
          tick_o <= 1'b0;
        end else if (ph_q == LAST) begin
          ph_q   <= '0;
          tick_o <= 1'b1;
        end else begin
          ph_q   <= ph_q + PW'(1);
          tick_o <= 1'b0;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/irq_thr_gap.sv
module irq_thr_gap
  import irq_thr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int IVAL_RST = 4000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic               fire_i,
  input  logic [1:0]         we_i,
  input  logic [2*CNT_W-1:0] wdata_i,
  output logic               zero_o,
  output logic [2*CNT_W-1:0] rd_o
);

  localparam logic [CNT_W-1:0] IVAL_INIT = CNT_W'(IVAL_RST);

  logic [CNT_W-1:0] ival_q, ival_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  cnt_op_e          op;

  assign zero_o = (cnt_q == '0);

  // A software write wins over the load, and the load wins over a tick
  always_comb begin
    if (we_i[WE_CNT])            op = CNT_SET;
    else if (fire_i)             op = CNT_LOAD;
    else if (tick_i && !zero_o)  op = CNT_DEC;
    else                         op = CNT_HOLD;
  end

  always_comb begin
    case (op)
      CNT_SET:  cnt_n = wdata_i[2*CNT_W-1:CNT_W];
      CNT_LOAD: cnt_n = ival_q;
      CNT_DEC:  cnt_n = cnt_q - CNT_W'(1);
      default:  cnt_n = cnt_q;
    endcase
  end

  assign ival_n = we_i[WE_IVAL] ? wdata_i[CNT_W-1:0] : ival_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ival_q <= IVAL_INIT;
      cnt_q  <= '0;
      rd_o   <= {{CNT_W{1'b0}}, IVAL_INIT};
    end else begin
      ival_q <= ival_n;
      cnt_q  <= cnt_n;
      rd_o   <= {cnt_n, ival_n};
    end
  end

endmodule

// File: rtl/irq_thr_pend.sv
module irq_thr_pend (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic ack_i,
  input  logic zero_i,
  output logic fire_o,
  output logic pend_o,
  output logic irq_o
);

  logic pend_q, irq_q;

  assign fire_o = pend_q && !irq_q && zero_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (evt_i)               pend_q <= 1'b1;
      else if (ack_i && irq_q) pend_q <= 1'b0;

      if (fire_o)              irq_q <= 1'b1;
      else if (ack_i)          irq_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/irq_throttle.sv
module irq_throttle #(
  parameter int CNT_W    = 16,
  parameter int TICK_DIV = 25,
  parameter int IVAL_RST = 4000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evt_i,
  input  logic               ack_i,
  input  logic [1:0]         reg_we_i,
  input  logic [2*CNT_W-1:0] reg_wdata_i,
  output logic [2*CNT_W-1:0] reg_rdata_o,
  output logic               irq_o
);

  logic tick_w, fire_w, zero_w, pend_w;

  irq_thr_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick_w)
  );

  irq_thr_gap #(.CNT_W(CNT_W), .IVAL_RST(IVAL_RST)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_w),
    .fire_i  (fire_w),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .zero_o  (zero_w),
    .rd_o    (reg_rdata_o)
  );

  irq_thr_pend u_pend (
    .clk    (clk),
    .rst    (rst),
    .evt_i  (evt_i),
    .ack_i  (ack_i),
    .zero_i (zero_w),
    .fire_o (fire_w),
    .pend_o (pend_w),
    .irq_o  (irq_o)
  );

endmodule

// File: rtl/irq_throttle_chk.sv
module irq_throttle_chk #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               evt_i,
  input logic               ack_i,
  input logic [1:0]         we_i,
  input logic [2*CNT_W-1:0] rdata,
  input logic               irq,
  input logic               pend
);

  logic [CNT_W-1:0] cnt_f, ival_f;
  assign cnt_f  = rdata[2*CNT_W-1:CNT_W];
  assign ival_f = rdata[CNT_W-1:0];

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    irq && !ack_i |=> irq);

  // R6
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    irq && ack_i |=> !irq);

  // R4
  fire_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(cnt_f) == '0);

  // R5
  load_ival_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) && !$past(we_i[1]) |-> cnt_f == $past(ival_f));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(we_i[1]) && !$rose(irq) |->
      (cnt_f == $past(cnt_f)) || (cnt_f == $past(cnt_f) - CNT_W'(1)));

  // R11
  rise_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(pend));

  // R11
  evt_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
    evt_i |=> pend);

  // R7
  pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
    pend && !(ack_i && irq) |=> pend);

endmodule

bind irq_throttle irq_throttle_chk #(.CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .evt_i (evt_i),
  .ack_i (ack_i),
  .we_i  (reg_we_i),
  .rdata (reg_rdata_o),
  .irq   (irq_o),
  .pend  (pend_w)
);

// File: tb/irq_throttle_tb.sv
module irq_throttle_tb;

  localparam int TDIV = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic        evt, ack;
  logic [1:0]  we;
  logic [31:0] wd;
  logic [31:0] rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  int rise_t[16];
  int nrise;

  always #10 clk = ~clk;

  irq_throttle #(.CNT_W(16), .TICK_DIV(TDIV), .IVAL_RST(4000)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .evt_i       (evt),
    .ack_i       (ack),
    .reg_we_i    (we),
    .reg_wdata_i (wd),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // call at a falling edge; returns one falling edge later with the write applied
  task automatic wr(input logic [1:0] en, input logic [31:0] d);
    we = en; wd = d;
    @(negedge clk);
    we = 2'b00; wd = '0;
  endtask

  // watch n cycles, acknowledge every interrupt at once, record rise times
  task automatic watch(input int n, input bit hold);
    logic prev;
    prev  = irq;
    nrise = 0;
    evt   = hold;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (irq && !prev) begin
        if (nrise < 16) rise_t[nrise] = k;
        nrise++;
      end
      ack  = (irq && !ack) ? 1'b1 : 1'b0;
      prev = irq;
    end
    evt = 1'b0;
    ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    int prev_c, last, cur;
    rst = 1'b1; evt = 1'b0; ack = 1'b0; we = 2'b00; wd = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(rdata == 32'h0000_0FA0, "R1 reset register", rdata, 32'h0000_0FA0);
    chk(irq == 1'b0, "R1 reset irq", irq, 0);

    // R11 no event, spurious ack
    ok = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (irq) ok = 0;
    end
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    repeat (5) begin @(negedge clk); if (irq) ok = 0; end
    chk(ok, "R11 no irq without event", irq, 0);

    // R2 field writes
    wr(2'b01, 32'h1234_0007);
    chk(rdata == 32'h0000_0007, "R2 interval write only", rdata, 32'h0000_0007);
    wr(2'b10, 32'h0005_ABCD);
    chk(rdata == 32'h0005_0007, "R2 countdown write only", rdata, 32'h0005_0007);

    // R3 decrement cadence
    prev_c = 5; last = -1; ok = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      cur = rdata[31:16];
      if (cur != prev_c) begin
        if (cur != prev_c - 1) ok = 0;
        if (last >= 0 && (k - last) != TDIV) ok = 0;
        last = k; prev_c = cur;
      end
    end
    chk(ok, "R3 one step per tick", last, TDIV);
    chk(prev_c == 0, "R3 reaches zero", prev_c, 0);
    ok = 1;
    repeat (10) begin @(negedge clk); if (rdata[31:16] != 0) ok = 0; end
    chk(ok, "R3 holds at zero", rdata[31:16], 0);

    // R4 latency, R5 load
    evt = 1'b1; @(negedge clk); evt = 1'b0;
    chk(irq == 1'b0, "R4 not after first edge", irq, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R4 raised on second edge", irq, 1);
    chk(rdata[31:16] == 16'd7, "R5 countdown loaded", rdata[31:16], 7);

    // R6 level held, ack clears irq and pending
    ok = 1;
    repeat (15) begin @(negedge clk); if (!irq) ok = 0; end
    chk(ok, "R6 irq held until ack", irq, 1);
    evt = 1'b1; @(negedge clk); evt = 1'b0;  // merged into the outstanding irq
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk(irq == 1'b0, "R6 ack lowers irq", irq, 0);
    watch(40, 0);
    chk(nrise == 0, "R6 earlier events cleared by ack", nrise, 0);

    // R7 coalescing, R11 spurious ack during gap
    wr(2'b10, 32'h0014_0000);  // countdown 20
    repeat (3) begin
      evt = 1'b1; @(negedge clk); evt = 1'b0; @(negedge clk);
    end
    chk(irq == 1'b0, "R7 held off by gap", irq, 0);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    watch(100, 0);
    chk(nrise == 1, "R7 one irq for many events", nrise, 1);
    chk(nrise == 1, "R11 low ack keeps pending", nrise, 1);

    // R8 / R9 sweep over intervals
    for (int iv = 0; iv <= 8; iv++) begin
      int lo, hi;
      wr(2'b01, iv);
      wr(2'b10, 32'h0);
      watch(200, 1);
      lo = (iv == 0) ? 2 : (iv - 1) * TDIV + 2;
      hi = (iv == 0) ? 2 : iv * TDIV + 1;
      chk(nrise >= 5, "R8 enough interrupts", nrise, 5);
      for (int g = 1; g < 5; g++) begin
        int gap;
        gap = rise_t[g] - rise_t[g-1];
        if (iv == 0) chk(gap == 2, "R9 no throttling", gap, 2);
        else         chk(gap >= lo && gap <= hi, "R8 gap window", gap, lo);
      end
      watch(40, 0);
    end

    // R10 countdown override
    wr(2'b01, 32'd200);
    wr(2'b10, 32'h0);
    evt = 1'b1; @(negedge clk); evt = 1'b0; @(negedge clk);
    chk(irq == 1'b1, "R10 setup irq", irq, 1);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    evt = 1'b1; @(negedge clk); evt = 1'b0;
    repeat (10) @(negedge clk);
    chk(irq == 1'b0, "R10 gap holds", irq, 0);
    wr(2'b10, 32'h0032_0000);
    chk(rdata[31:16] == 16'd50, "R10 override value", rdata[31:16], 50);
    wr(2'b10, 32'h0);
    chk(rdata[31:16] == 16'd0 && irq == 1'b0, "R10 zero written", rdata[31:16], 0);
    @(negedge clk);
    chk(irq == 1'b1, "R10 release on next edge", irq, 1);
    ack = 1'b1; @(negedge clk); ack = 1'b0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule